// File: doc/BRIEF.md
# I2S Width-Adapting Stereo Receiver

This block is a slave-side deserializer for a standard I2S audio link. The bit clock, word-select and serial data lines come from an external transmitter. A local system clock running at least four times the bit-clock rate samples them. The block rebuilds each left and right sample and presents the pair on two fixed-width parallel outputs, with a one-cycle valid strobe.

The transmitter's word length does not have to be known. The block aligns every word on its most significant bit, which is the first bit after each word-select change. It counts bits until the next word-select change. A word longer than the configured width loses its surplus low-order bits. A word shorter than the configured width has its missing low-order bits filled with zeros. Sample bits pass through unchanged, so the two's-complement sign bit always lands in the top output bit.

Top module: `stereo_rx`

## Requirements
- R1: The first data bit sampled after a word-select change (on the second bit-clock rising edge after that change) is placed in output bit SAMPLE_W-1, and later bits follow toward bit 0, MSB first. Two's-complement values are passed through unchanged.
- R2: When a word carries more than SAMPLE_W bits, only its first SAMPLE_W bits are kept and the rest are discarded.
- R3: When a word carries fewer than SAMPLE_W bits, the received bits occupy the top of the output and the remaining low bits are zero.
- R4: Bits received while word-select was low appear on `leftOut`. Bits received while word-select was high appear on `rightOut`.
- R5: `pairValid` pulses high for exactly one system-clock cycle once per stereo frame, after the right word ends at the high-to-low word-select change. The pulse carries that frame's left and right words.
- R6: After reset, the word in progress when the first word-select change is seen is discarded. No pair is emitted until a complete left word and then a complete right word have been received.
- R7: `leftOut` and `rightOut` change only in the cycle in which `pairValid` is high.
- R8: While reset is asserted and after it is released, `pairValid` is low and both outputs are zero until the first pair is emitted.
- R9: Inputs pass through a synchronizer. With a system clock at least four times the bit clock, two valid pulses are never closer than eight system-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClkIn | input | 1 | External bit clock; data is sampled on its rising edge |
| chanSelIn | input | 1 | Word select: 0 = left, 1 = right |
| serDataIn | input | 1 | Serial audio data, MSB first |
| leftOut | output | SAMPLE_W | Last complete left sample |
| rightOut | output | SAMPLE_W | Last complete right sample |
| pairValid | output | 1 | One-cycle strobe: new stereo pair on the outputs |

## Verification
A bit counter that is off by one moves every sample by one bit position. This shows as a doubled or halved value on the first emitted pair, about one frame after reset. A wrong channel-tracking or arming state shows as a missing, extra or channel-swapped pair at the next high-to-low word-select change. Mixed word lengths, including words shorter and longer than the output width, expose faults in padding and truncation on the very pair that carries them. Reset is repeated between scenarios, so that start-up discard is tested with both a left and a right partial word.

// File: rtl/stereo_rx_pkg.sv
package stereo_rx_pkg;
  // Strobes handed from the control unit to the datapath, one bit-clock event at a time.
  typedef struct packed {
    logic takeBit;    // a bit-clock rising edge was detected and the link is primed
    logic bitVal;     // synchronized serial data at that edge
    logic wordDone;   // this bit is the last of the current word
    logic storeLeft;  // the finished word is a valid left sample
    logic emitPair;   // the finished word is a valid right sample: publish the pair
  } rxStrobe_t;
endpackage

// File: rtl/stereo_rx_ctrl.sv
module stereo_rx_ctrl
  import stereo_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClkIn,
  input  logic       chanSelIn,
  input  logic       serDataIn,
  output rxStrobe_t  strobe
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] clkSync, wsSync, dataSync;
  logic clkPrev;
  logic wsHeld;     // word select seen at the previous bit-clock rise
  logic primed;     // at least one rise seen since reset
  logic armed;      // at least one word-select change seen
  logic haveLeft;   // a complete left word is stored

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          clkSync  <= '0;
          wsSync   <= '0;
          dataSync <= '0;
        end else begin
          clkSync  <= serClkIn;
          wsSync   <= chanSelIn;
          dataSync <= serDataIn;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          clkSync  <= '0;
          wsSync   <= '0;
          dataSync <= '0;
        end else begin
          clkSync  <= {clkSync[TOP-1:0], serClkIn};
          wsSync   <= {wsSync[TOP-1:0], chanSelIn};
          dataSync <= {dataSync[TOP-1:0], serDataIn};
        end
      end
    end
  endgenerate

  logic rise, wsNow;
  assign rise  = clkSync[TOP] & ~clkPrev;
  assign wsNow = wsSync[TOP];

  always_comb begin
    strobe.takeBit   = rise & primed;
    strobe.bitVal    = dataSync[TOP];
    strobe.wordDone  = strobe.takeBit & (wsNow != wsHeld);
    strobe.storeLeft = strobe.wordDone & armed & ~wsHeld;
    strobe.emitPair  = strobe.wordDone & armed & wsHeld & haveLeft;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev  <= 1'b0;
      wsHeld   <= 1'b0;
      primed   <= 1'b0;
      armed    <= 1'b0;
      haveLeft <= 1'b0;
    end else begin
      clkPrev <= clkSync[TOP];
      if (rise) begin
        wsHeld <= wsNow;
        primed <= 1'b1;
      end
      if (strobe.wordDone)  armed    <= 1'b1;
      if (strobe.storeLeft) haveLeft <= 1'b1;
    end
  end
endmodule

// File: rtl/stereo_rx_dp.sv
module stereo_rx_dp
  import stereo_rx_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  rxStrobe_t           strobe,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut,
  output logic                pairValid
);
  localparam int CNT_W = $clog2(SAMPLE_W + 1);

  logic [SAMPLE_W-1:0] acc, accNext, leftHold;
  logic [CNT_W-1:0]    bitCnt, cntNext;

  // Place the incoming bit at its MSB-aligned slot; past SAMPLE_W bits nothing matches.
  always_comb begin
    accNext = acc;
    for (int i = 0; i < SAMPLE_W; i++) begin
      if (CNT_W'(SAMPLE_W - 1 - i) == bitCnt) accNext[i] = strobe.bitVal;
    end
    cntNext = (bitCnt == CNT_W'(SAMPLE_W)) ? bitCnt : bitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc       <= '0;
      bitCnt    <= '0;
      leftHold  <= '0;
      leftOut   <= '0;
      rightOut  <= '0;
      pairValid <= 1'b0;
    end else begin
      pairValid <= strobe.emitPair;
      if (strobe.takeBit) begin
        if (strobe.wordDone) begin
          acc    <= '0;
          bitCnt <= '0;
        end else begin
          acc    <= accNext;
          bitCnt <= cntNext;
        end
      end
      if (strobe.storeLeft) leftHold <= accNext;
      if (strobe.emitPair) begin
        leftOut  <= leftHold;
        rightOut <= accNext;
      end
    end
  end
endmodule

// File: rtl/stereo_rx.sv
module stereo_rx
  import stereo_rx_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                serClkIn,
  input  logic                chanSelIn,
  input  logic                serDataIn,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut,
  output logic                pairValid
);
  rxStrobe_t strobe;

  stereo_rx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl (
    .clk(clk), .rstN(rstN), .serClkIn(serClkIn), .chanSelIn(chanSelIn),
    .serDataIn(serDataIn), .strobe(strobe)
  );

  stereo_rx_dp #(.SAMPLE_W(SAMPLE_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .leftOut(leftOut), .rightOut(rightOut), .pairValid(pairValid)
  );
endmodule

// File: rtl/stereo_rx_chk.sv
module stereo_rx_chk #(
  parameter int SAMPLE_W = 16,
  parameter int MIN_GAP  = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [SAMPLE_W-1:0] leftOut,
  input logic [SAMPLE_W-1:0] rightOut,
  input logic                pairValid
);
  logic [7:0] gap;
  logic       seen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (pairValid) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != 8'hFF) begin
      gap <= gap + 1'b1;
    end
  end

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |=> !pairValid);

  // R7
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pairValid |-> ($stable(leftOut) && $stable(rightOut)));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (!pairValid && leftOut == '0 && rightOut == '0));

  // R9
  pair_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pairValid && seen) |-> (int'(gap) >= MIN_GAP - 1));
endmodule

bind stereo_rx stereo_rx_chk #(.SAMPLE_W(SAMPLE_W)) chkInst (
  .clk(clk), .rstN(rstN), .leftOut(leftOut), .rightOut(rightOut), .pairValid(pairValid)
);

// File: tb/stereo_rx_test.sv
`timescale 1ns/1ps
module stereo_rx_test;
  localparam int W = 16;

  logic clk = 1'b0, rstN = 1'b0, bclk = 1'b0, ws = 1'b0, sd = 1'b0;
  logic [W-1:0] leftOut, rightOut;
  logic pairValid;

  stereo_rx #(.SAMPLE_W(W)) uut (
    .clk(clk), .rstN(rstN), .serClkIn(bclk), .chanSelIn(ws), .serDataIn(sd),
    .leftOut(leftOut), .rightOut(rightOut), .pairValid(pairValid)
  );

  always #2.5 clk = ~clk;

  logic qBit[$];
  logic qWs[$];
  logic [W-1:0] expL[$];
  logic [W-1:0] expR[$];
  string expTag[$];
  int checks = 0, errors = 0, pairsSeen = 0;
  logic [W-1:0] lastL = '0, lastR = '0;
  bit stableBad = 0;
  bit done = 0;

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] fitWord(logic [31:0] v, int len);
    if (len >= W) return W'(v >> (len - W));
    else return W'(v << (W - len));
  endfunction

  function automatic logic [31:0] maskOf(int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
  endfunction

  task automatic pushWord(logic ch, int len, logic [31:0] v);
    for (int i = len - 1; i >= 0; i--) begin
      qBit.push_back(v[i]);
      qWs.push_back(ch);
    end
  endtask

  task automatic pushFrame(int lenL, logic [31:0] vL, int lenR, logic [31:0] vR, string tag);
    logic [31:0] l, r;
    l = vL & maskOf(lenL);
    r = vR & maskOf(lenR);
    pushWord(1'b0, lenL, l);
    pushWord(1'b1, lenR, r);
    expL.push_back(fitWord(l, lenL));
    expR.push_back(fitWord(r, lenR));
    expTag.push_back(tag);
  endtask

  task automatic pushRandomFrame();
    int a, b;
    a = 2 + int'($urandom % 31);
    b = 2 + int'($urandom % 31);
    pushFrame(a, $urandom, b, $urandom, "R1 random lengths");
  endtask

  // Word select leads data by one bit: it takes the channel of the next bit.
  task automatic driveStream();
    int n;
    n = qBit.size();
    for (int i = 0; i < n; i++) begin
      bclk = 1'b0;
      sd = qBit[i];
      ws = (i + 1 < n) ? qWs[i + 1] : qWs[i];
      repeat (4) @(posedge clk);
      #1;
      bclk = 1'b1;
      repeat (4) @(posedge clk);
      #1;
    end
    qBit.delete();
    qWs.delete();
    repeat (20) @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    bclk = 1'b0; ws = 1'b0; sd = 1'b0;
    rstN = 1'b0;
    repeat (6) @(posedge clk);
    #1;
    rstN = 1'b1;
    lastL = '0;
    lastR = '0;
    repeat (4) @(posedge clk);
    #1;
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (pairValid) begin
        pairsSeen++;
        if (expL.size() == 0) begin
          check(1'b0, "R6 unexpected pair", leftOut, '0);
        end else begin
          logic [W-1:0] eL, eR;
          string t;
          eL = expL.pop_front();
          eR = expR.pop_front();
          t = expTag.pop_front();
          check(leftOut == eL, {t, " left (R4)"}, leftOut, eL);
          check(rightOut == eR, {t, " right (R4)"}, rightOut, eR);
        end
        lastL = leftOut;
        lastR = rightOut;
      end else if (leftOut != lastL || rightOut != lastR) begin
        stableBad = 1;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state
    check(pairValid == 1'b0, "R8 valid low in reset", {{(W-1){1'b0}}, pairValid}, '0);
    check(leftOut == '0, "R8 left zero in reset", leftOut, '0);
    check(rightOut == '0, "R8 right zero in reset", rightOut, '0);
    doReset();

    // Scenario 1: partial right word first (R6), then directed and random frames.
    pairsSeen = 0;
    pushWord(1'b1, 5, 32'h15);
    pushFrame(W, 32'h8001, W, 32'h7FFE, "R1 exact width sign bits");
    pushFrame(24, 32'hA5C3_E1, 20, 32'h9_1234, "R2 long words");
    pushFrame(8, 32'h81, 12, 32'hF0F, "R3 short words");
    pushFrame(32, 32'hDEAD_BEEF, 2, 32'h2, "R2 R3 extremes");
    pushFrame(W, 32'h1234, W, 32'hABCD, "R4 channel order");
    for (int k = 0; k < 20; k++) pushRandomFrame();
    pushWord(1'b0, 3, 32'h5);
    driveStream();
    check(pairsSeen == 25, "R5 pair count scenario 1", W'(pairsSeen), W'(25));
    check(expL.size() == 0, "R5 all pairs emitted", W'(expL.size()), '0);

    // Scenario 2: partial left then a lone right word: no pair until a full left (R6).
    doReset();
    check(leftOut == '0 && rightOut == '0, "R8 outputs cleared after reset", leftOut | rightOut, '0);
    pairsSeen = 0;
    pushWord(1'b0, 7, 32'h55);
    pushWord(1'b1, 12, 32'hFFF);
    pushFrame(16, 32'hFFFF, 4, 32'h9, "R6 first full frame");
    for (int k = 0; k < 6; k++) pushRandomFrame();
    pushWord(1'b0, 3, 32'h2);
    driveStream();
    check(pairsSeen == 7, "R6 pair count scenario 2", W'(pairsSeen), W'(7));
    check(expL.size() == 0, "R6 no missing pair", W'(expL.size()), '0);
    check(!stableBad, "R7 outputs held between pairs", W'(stableBad), '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule